// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Controller

This block is the bus-side controller of a 512-byte serial EEPROM on a two-wire bus. The bus clock arrives as an input, and the data line is open-drain: the block reads the line level and has a pull-low enable. The block finds the frame boundaries and checks the control byte against its device code and strap pins. In a write transfer it loads a 9-bit word pointer and passes each data byte to an external page store through a one-cycle byte-write strobe. In a read transfer it shifts out bytes that it fetches from the same byte port.

A STOP that ends a write transfer with at least one data byte starts a timed programming interval. During that interval the block ignores its own address. A master therefore learns that programming has finished by repeatedly sending a control byte until one is acknowledged. The storage array and the page buffer are outside this block.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe` low), `wr_busy` is low and `mem_we` is low.
- R2: A control byte whose upper nibble (bits 7:4, first four bits on the wire) is not 1010 gets no acknowledge and causes no write.
- R3: Control bits 3:2 must equal `strap_i[1:0]` (bit 3 to `strap_i[1]`) or the byte is not acknowledged; control bit 1 is not compared.
- R4: Every byte the block accepts is acknowledged by holding SDA low through the entire high phase of the ninth SCL pulse.
- R5: In a write (control bit 0 = 0), the second byte becomes the word pointer, and each later byte gives exactly one `mem_we` cycle with `mem_addr` = pointer and `mem_wdata` = the byte.
- R6: A STOP after at least one complete data byte holds `wr_busy` high for exactly WR_CYCLES clock cycles. A STOP with no complete data byte leaves it low.
- R7: Control bit 1 becomes bit 8 of the pointer when the word address byte is loaded.
- R8: While `wr_busy` is high, a matching control byte of either direction gets no acknowledge.
- R9: After each written byte, only the low 4 pointer bits increment and wrap. A 17th byte in one transfer overwrites the first.
- R10: In a read (control bit 0 = 1), each byte is the memory content at the pointer, sent MSB first, and the pointer then increments across all 9 bits. A master acknowledge requests the next byte.
- R11: When the master does not acknowledge a read byte, the block releases SDA and keeps it released until the next START.
- R12: A START or STOP in the middle of a byte abandons the transfer: the pointer is not reloaded, no write occurs, and a following transfer works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when high |
| strap_i | input | 2 | Chip-select strap pins compared with control bits 3:2 |
| mem_addr | output | 9 | Byte address for the storage port |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | One-cycle byte write strobe |
| mem_rdata | input | 8 | Byte at `mem_addr`, combinational |
| wr_busy | output | 1 | Programming interval in progress |

## Verification
The assertions assume that SCL and SDA each stay at a level for longer than the two-flop synchronizer delay. They also assume that the master changes SDA only while SCL is low, except for START and STOP, and never signals START or STOP while the slave is pulling SDA low. Under those conditions the slave's pull-low enable changes only while SCL is low. The bench master keeps every SCL phase at least eight clocks long and moves SDA in the middle of the low phase. It issues STOP and repeated START only after the slave has released the line.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter int         PAGE_BITS = 4,
  parameter int         WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_i,
  output logic [8:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  input  logic [7:0] mem_rdata,
  output logic       wr_busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDATA, S_READ} st_t;

  st_t         st;
  logic [1:0]  scl_m, sda_m;
  logic        scl_d, sda_d;
  logic [7:0]  sh;
  logic [3:0]  bc;
  logic [8:0]  ptr;
  logic        blk, rd, mack, got;
  logic [CW-1:0] cnt;

  wire scl_s   = scl_m[1];
  wire sda_s   = sda_m[1];
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise    = scl_s & ~scl_d;
  wire fall    = ~scl_s & scl_d;
  wire hit     = (sh[7:4] == DEV_CODE) && (sh[3:2] == strap_i) && !wr_busy;
  wire [8:0] pg_next = {ptr[8:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};

  assign wr_busy   = (cnt != '0);
  assign mem_addr  = ptr;
  assign mem_wdata = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= '0;
      bc     <= '0;
      ptr    <= '0;
      blk    <= 1'b0;
      rd     <= 1'b0;
      mack   <= 1'b0;
      got    <= 1'b0;
      sda_oe <= 1'b0;
      mem_we <= 1'b0;
      cnt    <= '0;
    end else begin
      mem_we <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (start_c) begin
        st     <= S_CTRL;
        bc     <= '0;
        sda_oe <= 1'b0;
        got    <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        bc     <= '0;
        sda_oe <= 1'b0;
        got    <= 1'b0;
        if (got) cnt <= CW'(WR_CYCLES);
      end else begin
        case (st)
          S_CTRL, S_ADDR, S_WDATA: begin
            if (rise && bc < 4'd8) begin
              sh <= {sh[6:0], sda_s};
              bc <= bc + 1'b1;
            end else if (fall && bc == 4'd8) begin
              bc <= 4'd9;
              if (st == S_CTRL) begin
                if (hit) begin
                  sda_oe <= 1'b1;
                  blk    <= sh[1];
                  rd     <= sh[0];
                end else begin
                  st <= S_IDLE;
                  bc <= '0;
                end
              end else if (st == S_ADDR) begin
                sda_oe <= 1'b1;
                ptr    <= {blk, sh};
              end else begin
                sda_oe <= 1'b1;
                mem_we <= 1'b1;
                got    <= 1'b1;
              end
            end else if (fall && bc == 4'd9) begin
              bc     <= '0;
              sda_oe <= 1'b0;
              if (st == S_CTRL && rd) begin
                st     <= S_READ;
                sh     <= mem_rdata;
                ptr    <= ptr + 1'b1;
                sda_oe <= ~mem_rdata[7];
              end else if (st == S_CTRL) begin
                st <= S_ADDR;
              end else if (st == S_ADDR) begin
                st <= S_WDATA;
              end else begin
                ptr <= pg_next;
              end
            end
          end
          S_READ: begin
            if (rise && bc < 4'd8) begin
              bc <= bc + 1'b1;
            end else if (rise && bc == 4'd8) begin
              mack <= ~sda_s;
              bc   <= 4'd9;
            end else if (fall && bc != 4'd0 && bc < 4'd8) begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end else if (fall && bc == 4'd8) begin
              sda_oe <= 1'b0;
            end else if (fall && bc == 4'd9) begin
              bc <= '0;
              if (mack) begin
                sh     <= mem_rdata;
                ptr    <= ptr + 1'b1;
                sda_oe <= ~mem_rdata[7];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: bc <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_c,
  input logic sda_oe,
  input logic mem_we,
  input logic wr_busy
);
  p_sda_still_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_no_we_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !mem_we);

  p_busy_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(stop_c));

  p_silent_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !sda_oe);
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_s   (scl_s),
  .stop_c  (stop_c),
  .sda_oe  (sda_oe),
  .mem_we  (mem_we),
  .wr_busy (wr_busy)
);

// File: tb/sim_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_slave;
  localparam int WRC = 2000;
  localparam int Q = 8;
  localparam int H = 20;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe, mem_we, wr_busy;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] bmem [512];
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0, we_cnt = 0, blen = 0;
  logic busy_q = 0;

  always #5 clk = ~clk;

  eeprom_i2c_slave #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(2'b10), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .wr_busy(wr_busy));

  assign mem_rdata = bmem[mem_addr];

  initial for (int i = 0; i < 512; i++) bmem[i] = 8'(i * 7 + 3);

  always @(posedge clk) if (mem_we) begin
    bmem[mem_addr] <= mem_wdata;
    we_cnt <= we_cnt + 1;
  end

  always @(negedge clk) begin
    if (wr_busy && !busy_q) blen = 1;
    else if (wr_busy) blen = blen + 1;
    busy_q = wr_busy;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start;
    tick(Q); sda_m = 1; tick(Q); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0;
  endtask

  task automatic bus_stop;
    tick(Q); sda_m = 0; tick(Q); scl_m = 1; tick(H); sda_m = 1; tick(H);
  endtask

  task automatic send_bit(bit b);
    tick(Q); sda_m = b; tick(Q); scl_m = 1; tick(H); scl_m = 0;
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack, output bit nak);
    bit all_low = 1, any_low = 0;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    tick(Q); sda_m = 1; tick(Q); scl_m = 1;
    for (int i = 0; i < H; i++) begin
      tick(1);
      all_low &= ~sda_line;
      any_low |= ~sda_line;
    end
    scl_m = 0;
    ack = all_low;
    nak = ~any_low;
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] b, output bit line_hi);
    bit hi = 1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); sda_m = 1; tick(Q); scl_m = 1; tick(H / 2);
      b = {b[6:0], sda_line}; tick(H / 2); scl_m = 0;
    end
    tick(Q); sda_m = ~give_ack; tick(Q); scl_m = 1;
    for (int i = 0; i < H; i++) begin
      tick(1);
      if (!give_ack) hi &= sda_line;
    end
    scl_m = 0;
    if (!give_ack) begin
      tick(Q);
      hi &= sda_line;
    end
    line_hi = hi;
  endtask

  task automatic wait_ready;
    for (int i = 0; i < 4 * WRC && wr_busy; i++) tick(1);
  endtask

  task automatic t_reset;
    chk(sda_oe == 0, "R1", "sda_oe", sda_oe, 0);
    chk(wr_busy == 0, "R1", "wr_busy", wr_busy, 0);
    chk(mem_we == 0, "R1", "mem_we", mem_we, 0);
  endtask

  task automatic t_select;
    bit a, n;
    int w0 = we_cnt;
    bus_start(); send_byte(8'h58, a, n); bus_stop();
    chk(n, "R2", "wrong device code not acked", n, 1);
    bus_start(); send_byte(8'hA4, a, n); bus_stop();
    chk(n, "R3", "strap mismatch not acked", n, 1);
    bus_start(); send_byte(8'hAA, a, n); bus_stop();
    chk(a, "R3", "bit 1 not compared", a, 1);
    chk(we_cnt == w0 && !wr_busy, "R2", "no write from rejected bytes", we_cnt - w0, 0);
  endtask

  task automatic t_byte_write_poll;
    bit a, n;
    bus_start();
    send_byte(8'hA8, a, n); chk(a, "R4", "ack control", a, 1);
    send_byte(8'h35, a, n); chk(a, "R4", "ack word address", a, 1);
    send_byte(8'h6C, a, n); chk(a, "R4", "ack data", a, 1);
    bus_stop();
    chk(bmem[9'h035] == 8'h6C, "R5", "mem[035]", bmem[9'h035], 8'h6C);
    chk(wr_busy, "R6", "busy after stop", wr_busy, 1);
    bus_start(); send_byte(8'hA8, a, n); bus_stop();
    chk(n, "R8", "write poll not acked while busy", n, 1);
    bus_start(); send_byte(8'hA9, a, n); bus_stop();
    chk(n, "R8", "read poll not acked while busy", n, 1);
    chk(wr_busy, "R8", "still busy during polls", wr_busy, 1);
    wait_ready(); tick(2);
    chk(blen == WRC, "R6", "busy length", blen, WRC);
    bus_start(); send_byte(8'hA8, a, n); bus_stop();
    chk(a, "R8", "poll acked after completion", a, 1);
    tick(4);
    chk(!wr_busy, "R6", "no busy without data byte", wr_busy, 0);
  endtask

  task automatic t_block_bit;
    bit a, n;
    logic [7:0] lo = bmem[9'h080];
    bus_start(); send_byte(8'hAA, a, n); send_byte(8'h80, a, n); send_byte(8'h5A, a, n); bus_stop();
    chk(bmem[9'h180] == 8'h5A, "R7", "mem[180]", bmem[9'h180], 8'h5A);
    chk(bmem[9'h080] == lo, "R7", "mem[080] untouched", bmem[9'h080], lo);
    wait_ready();
  endtask

  task automatic t_page;
    bit a, n;
    logic [7:0] nxt = bmem[9'h020];
    int w0 = we_cnt;
    bus_start(); send_byte(8'hA8, a, n); send_byte(8'h1E, a, n);
    for (int i = 0; i < 17; i++) send_byte(8'(8'hC0 + i), a, n);
    bus_stop();
    chk(we_cnt - w0 == 17, "R5", "one strobe per byte", we_cnt - w0, 17);
    chk(bmem[9'h01E] == 8'hD0, "R9", "mem[01E] overwritten", bmem[9'h01E], 8'hD0);
    chk(bmem[9'h01F] == 8'hC1, "R9", "mem[01F]", bmem[9'h01F], 8'hC1);
    chk(bmem[9'h010] == 8'hC2, "R9", "mem[010] wrapped", bmem[9'h010], 8'hC2);
    chk(bmem[9'h01D] == 8'hCF, "R9", "mem[01D]", bmem[9'h01D], 8'hCF);
    chk(bmem[9'h020] == nxt, "R9", "mem[020] untouched", bmem[9'h020], nxt);
    wait_ready();
  endtask

  task automatic t_read;
    bit a, n, hi;
    logic [7:0] b;
    logic [7:0] e0 = bmem[9'h1FE], e1 = bmem[9'h1FF], e2 = bmem[9'h000];
    bus_start(); send_byte(8'hAA, a, n); send_byte(8'hFE, a, n);
    bus_start(); send_byte(8'hA9, a, n);
    chk(a, "R10", "read control acked", a, 1);
    recv_byte(1, b, hi); chk(b == e0, "R10", "byte 1FE", b, e0);
    recv_byte(1, b, hi); chk(b == e1, "R10", "byte 1FF", b, e1);
    recv_byte(0, b, hi); chk(b == e2, "R10", "byte 000 after wrap", b, e2);
    chk(hi, "R11", "SDA released after master nack", hi, 1);
    chk(!sda_oe, "R11", "sda_oe low after nack", sda_oe, 0);
    bus_stop();
    chk(!wr_busy, "R6", "read causes no busy", wr_busy, 0);
  endtask

  task automatic t_abort;
    bit a, n, hi;
    logic [7:0] b;
    logic [7:0] e = bmem[9'h001];
    int w0 = we_cnt;
    bus_start(); for (int i = 0; i < 4; i++) send_bit(i[0] ? 1'b0 : 1'b1); bus_stop();
    chk(!sda_oe && !wr_busy, "R12", "idle after stop in control byte", sda_oe, 0);
    bus_start(); send_byte(8'hA8, a, n); send_bit(1); send_bit(1); send_bit(0);
    bus_start(); send_byte(8'hA9, a, n);
    chk(a, "R12", "ack after start inside address byte", a, 1);
    recv_byte(0, b, hi); bus_stop();
    chk(b == e, "R12", "pointer not reloaded", b, e);
    bus_start(); send_byte(8'hA8, a, n); send_byte(8'h40, a, n);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop(); tick(4);
    chk(we_cnt == w0, "R12", "no write from partial byte", we_cnt - w0, 0);
    chk(!wr_busy, "R12", "no busy from partial byte", wr_busy, 0);
  endtask

  initial begin
    tick(5);
    t_reset();
    rst_n = 1;
    tick(5);
    t_select();
    t_byte_write_poll();
    t_block_bit();
    t_page();
    t_read();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule